// File: doc/BRIEF.md
# Random-Frequency Stacked Triangular Carrier Generator

This block produces a family of triangular carriers that share one phase and one frequency and sit in adjacent amplitude bands, and it compares each band against a signed reference meant for the low-voltage cells of a multilevel inverter. The carrier period is not fixed. At every valley of the triangle a new half-period count is drawn as a centre count plus a random fraction of a spread count. The random fraction comes from a pseudo-random source in the range [-1, 1). Spreading the switching frequency this way disperses switching noise instead of concentrating it at one carrier frequency and its harmonics.

The source is chosen by a parameter: either a chaotic logistic map, or a 16-bit linear-feedback shift register. The seed is taken while reset is held. The block gives one raw comparison pulse per band and a one-cycle strobe at each carrier valley, so that downstream pulse distribution and dead-time logic can sample at a consistent point. Those downstream functions are not part of this block.

The reference is in fixed point, with one cell voltage step E equal to 2^FRAC_W counts (256 at the default). There are NB bands above zero and NB bands below zero (three each at the default), and each band is E tall.

Top module: `rfcar_gen`

## Requirements
- R1: While rst_n is low, every pulse output and period_start are 0 and the random state loads `seed`. A seed of zero is replaced by 1. Any other seed is used unchanged.
- R2: The internal carrier count c runs 0, 1, …, H, H−1, …, 1, 0, so each carrier period is exactly 2·H clock cycles. The first cycle after reset is a valley. period_start is high for exactly one cycle per period. All outputs are registered and show the state of the previous cycle, so period_start is high in the cycle after c is 0.
- R3: H is latched only at a valley, and it is then held for the whole period. Its value is H = center_half + floor(rn·spread_half / 2^15), clamped to the range 1 to 2^CNT_W−1. Here rn is the signed 16-bit random value, read as Q1.15.
- R4: In logistic mode the 16-bit state x is read as Q0.16. It advances by x' = floor(R·x·(65536−x) / 2^30), where R = 0xFFF0 is read in Q2.14 (about 3.999). If x' is 0 it becomes 1. The random value is rn = x − 32768.
- R5: In shift-register mode the state shifts right by one bit. When the bit shifted out is 1, the new state is XORed with 0xB400. The random value is rn = the state read as a signed 16-bit number.
- R6: The pulse for positive band k (k = 0 … NB−1, output pulse_pos[k]) is 1 when (ref − k·E)·H > c·E.
- R7: The pulse for negative band k (output pulse_neg[k]) is 1 when (ref + (k+1)·E)·H > c·E. Band 0 is the band just below zero.
- R8: The pulse outputs form a thermometer code. In the order pulse_neg[NB−1], …, pulse_neg[0], pulse_pos[0], …, pulse_pos[NB−1], no 1 ever appears above a 0.
- R9: The random state advances exactly once per carrier period, at the valley where the new H is taken from the current random value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the seed is loaded while it is low |
| center_half | input | CNT_W | Centre half-period in clock cycles |
| spread_half | input | CNT_W | Maximum deviation of the half-period in clock cycles |
| seed | input | 16 | Initial random state |
| ref_lv | input | REF_W | Signed low-cell reference; E = 2^FRAC_W counts |
| pulse_pos | output | NB | Comparison pulses of the positive bands |
| pulse_neg | output | NB | Comparison pulses of the negative bands |
| period_start | output | 1 | One-cycle strobe at each carrier valley |

## Verification
The assertions check several properties on every cycle:
- the carrier count moves by exactly one step per cycle and never exceeds the latched half-period;
- the half-period changes only at a valley, and is never zero;
- the random state is never zero;
- two strobes are never adjacent;
- the band pulses always form a thermometer code.

Only the bench's scenarios can show that the drawn periods follow the exact logistic and shift-register sequences and the clamping formula. The same holds for the exact pulse edges at the band boundaries (reference at 0, ±E and ±3E, and beyond the full range) and the replacement of a zero seed. The bench shows these by running both random sources against an independent cycle model.

// File: rtl/rfcar_pkg.sv
package rfcar_pkg;
   localparam int RN_W = 16;

   typedef enum logic [0:0] {
      RNG_LOGISTIC = 1'b0,
      RNG_LFSR     = 1'b1
   } rng_kind_e;

   function automatic logic [RN_W-1:0] seed_fix(input logic [RN_W-1:0] s);
      return (s == '0) ? RN_W'(1) : s;
   endfunction
endpackage

// File: rtl/rfcar_rng.sv
module rfcar_rng #(
   parameter rfcar_pkg::rng_kind_e KIND   = rfcar_pkg::RNG_LOGISTIC,
   parameter logic [15:0]          LOGI_R = 16'hFFF0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [15:0]         seed,
   input  logic                adv,
   output logic signed [15:0]  rn,
   output logic [15:0]         state
);
   logic [15:0] st_q, st_nx;

   generate
      if (KIND == rfcar_pkg::RNG_LOGISTIC) begin : g_logi
         logic [16:0] omx;
         logic [32:0] p1;
         logic [48:0] p2;
         logic [15:0] raw;
         always_comb begin
            omx   = 17'h10000 - {1'b0, st_q};
            p1    = 33'(st_q) * 33'(omx);
            p2    = 49'(p1) * 49'(LOGI_R);
            raw   = p2[45:30];
            st_nx = (raw == '0) ? 16'd1 : raw;
         end
         assign rn = $signed(st_q ^ 16'h8000);
      end else begin : g_lfsr
         always_comb begin
            st_nx = {1'b0, st_q[15:1]};
            if (st_q[0]) st_nx = st_nx ^ 16'hB400;
         end
         assign rn = $signed(st_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= rfcar_pkg::seed_fix(seed);
      else if (adv) st_q <= st_nx;
   end

   assign state = st_q;
endmodule

// File: rtl/rfcar_period.sv
module rfcar_period #(
   parameter int CNT_W = 12
) (
   input  logic [CNT_W-1:0]   center,
   input  logic [CNT_W-1:0]   spread,
   input  logic signed [15:0] rn,
   output logic [CNT_W-1:0]   h_new
);
   localparam int SW = CNT_W + rfcar_pkg::RN_W + 2;
   localparam logic signed [SW-1:0] HMAX = SW'((2 ** CNT_W) - 1);

   logic signed [SW-1:0] rn_x, sp_x, prod, dev, sum;

   always_comb begin
      rn_x = SW'(rn);
      sp_x = $signed(SW'(spread));
      prod = rn_x * sp_x;
      dev  = prod >>> (rfcar_pkg::RN_W - 1);
      sum  = $signed(SW'(center)) + dev;
      if (sum < SW'(1))     h_new = CNT_W'(1);
      else if (sum > HMAX)  h_new = HMAX[CNT_W-1:0];
      else                  h_new = sum[CNT_W-1:0];
   end
endmodule

// File: rtl/rfcar_tri.sv
module rfcar_tri #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] h_new,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] half,
   output logic             valley
);
   logic [CNT_W-1:0] cnt_q, half_q;
   logic             up_q;

   assign valley = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         half_q <= CNT_W'(1);
         up_q   <= 1'b1;
      end else if (valley) begin
         half_q <= h_new;
         cnt_q  <= CNT_W'(1);
         up_q   <= 1'b1;
      end else if (up_q && cnt_q == half_q) begin
         up_q  <= 1'b0;
         cnt_q <= cnt_q - CNT_W'(1);
      end else if (up_q) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end else begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign cnt  = cnt_q;
   assign half = half_q;
endmodule

// File: rtl/rfcar_band_cmp.sv
module rfcar_band_cmp #(
   parameter int CNT_W  = 12,
   parameter int FRAC_W = 8,
   parameter int REF_W  = 11,
   parameter int OFFSET = 0
) (
   input  logic signed [REF_W-1:0] ref_lv,
   input  logic [CNT_W-1:0]        cnt,
   input  logic [CNT_W-1:0]        half,
   output logic                    hit
);
   localparam int DW = REF_W + 1;
   localparam int MW = DW + CNT_W + 1;
   localparam logic signed [DW-1:0] BASE = DW'(OFFSET * (2 ** FRAC_W));

   logic signed [DW-1:0] diff;
   logic signed [MW-1:0] lhs, rhs;

   always_comb begin
      diff = DW'(ref_lv) - BASE;
      lhs  = MW'(diff) * $signed(MW'(half));
      rhs  = $signed(MW'({cnt, {FRAC_W{1'b0}}}));
      hit  = lhs > rhs;
   end
endmodule

// File: rtl/rfcar_gen.sv
module rfcar_gen #(
   parameter int                   CNT_W    = 12,
   parameter int                   FRAC_W   = 8,
   parameter int                   NB       = 3,
   parameter int                   REF_W    = 11,
   parameter rfcar_pkg::rng_kind_e RNG_KIND = rfcar_pkg::RNG_LOGISTIC,
   parameter logic [15:0]          LOGI_R   = 16'hFFF0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W-1:0]        center_half,
   input  logic [CNT_W-1:0]        spread_half,
   input  logic [15:0]             seed,
   input  logic signed [REF_W-1:0] ref_lv,
   output logic [NB-1:0]           pulse_pos,
   output logic [NB-1:0]           pulse_neg,
   output logic                    period_start
);
   localparam int FULL_SCALE = NB * (2 ** FRAC_W);

   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt
         $error("rfcar_gen: CNT_W out of range");
      end
      if (NB < 1) begin : g_bad_nb
         $error("rfcar_gen: NB must be at least 1");
      end
      if (FULL_SCALE > (2 ** (REF_W - 1)) - 1) begin : g_bad_ref
         $error("rfcar_gen: REF_W too narrow for NB bands of 2^FRAC_W");
      end
   endgenerate

   logic signed [15:0] rn;
   logic [15:0]        rng_state;
   logic [CNT_W-1:0]   h_new, cnt, half_q;
   logic               valley;
   logic [NB-1:0]      hit_pos, hit_neg;

   rfcar_rng #(.KIND(RNG_KIND), .LOGI_R(LOGI_R)) u_rng (
      .clk(clk), .rst_n(rst_n), .seed(seed), .adv(valley),
      .rn(rn), .state(rng_state)
   );

   rfcar_period #(.CNT_W(CNT_W)) u_period (
      .center(center_half), .spread(spread_half), .rn(rn), .h_new(h_new)
   );

   rfcar_tri #(.CNT_W(CNT_W)) u_tri (
      .clk(clk), .rst_n(rst_n), .h_new(h_new),
      .cnt(cnt), .half(half_q), .valley(valley)
   );

   for (genvar k = 0; k < NB; k++) begin : g_band
      rfcar_band_cmp #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .REF_W(REF_W), .OFFSET(k)) u_pos (
         .ref_lv(ref_lv), .cnt(cnt), .half(half_q), .hit(hit_pos[k])
      );
      rfcar_band_cmp #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .REF_W(REF_W), .OFFSET(-(k + 1))) u_neg (
         .ref_lv(ref_lv), .cnt(cnt), .half(half_q), .hit(hit_neg[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_pos    <= '0;
         pulse_neg    <= '0;
         period_start <= 1'b0;
      end else begin
         pulse_pos    <= hit_pos;
         pulse_neg    <= hit_neg;
         period_start <= valley;
      end
   end
endmodule

// File: rtl/rfcar_gen_chk.sv
module rfcar_gen_chk #(
   parameter int CNT_W = 12,
   parameter int NB    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] half_q,
   input logic [15:0]      rng_state,
   input logic [NB-1:0]    pulse_pos,
   input logic [NB-1:0]    pulse_neg,
   input logic             period_start
);
   logic [2*NB-1:0] therm;
   logic [2*NB:0]   therm_p1;

   always_comb begin
      for (int k = 0; k < NB; k++) begin
         therm[NB + k]     = pulse_pos[k];
         therm[NB - 1 - k] = pulse_neg[k];
      end
      therm_p1 = {1'b0, therm} + (2*NB+1)'(1);
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt) + CNT_W'(1)) || (cnt == $past(cnt) - CNT_W'(1))); // R2
   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= half_q); // R2
   AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |=> !period_start); // R2
   AST_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> $stable(half_q)); // R3
   AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      half_q != '0); // R3
   AST_RNG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> $stable(rng_state)); // R9
   AST_RNG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rng_state != '0); // R4
   AST_THERMOMETER: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_p1[2*NB-1:0] & therm) == '0); // R8
endmodule

bind rfcar_gen rfcar_gen_chk #(.CNT_W(CNT_W), .NB(NB)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt), .half_q(half_q), .rng_state(rng_state),
   .pulse_pos(pulse_pos), .pulse_neg(pulse_neg), .period_start(period_start)
);

// File: tb/rfcar_gen_tb.sv
`timescale 1ns/1ps
module rfcar_gen_tb;
   localparam int CNT_W = 12;
   localparam int FRAC_W = 8;
   localparam int NB = 3;
   localparam int REF_W = 11;
   localparam int E = 2 ** FRAC_W;
   localparam int HMAX = (2 ** CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CNT_W-1:0] center_half = 12'd20;
   logic [CNT_W-1:0] spread_half = 12'd10;
   logic [15:0] seed = 16'h1D2B;
   logic signed [REF_W-1:0] ref_lv = '0;
   logic [NB-1:0] pos0, neg0, pos1, neg1;
   logic stb0, stb1;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   rfcar_gen #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .NB(NB), .REF_W(REF_W),
               .RNG_KIND(rfcar_pkg::RNG_LOGISTIC)) u_dut (
      .clk(clk), .rst_n(rst_n), .center_half(center_half), .spread_half(spread_half),
      .seed(seed), .ref_lv(ref_lv), .pulse_pos(pos0), .pulse_neg(neg0), .period_start(stb0)
   );

   rfcar_gen #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .NB(NB), .REF_W(REF_W),
               .RNG_KIND(rfcar_pkg::RNG_LFSR)) u_dut_lfsr (
      .clk(clk), .rst_n(rst_n), .center_half(center_half), .spread_half(spread_half),
      .seed(seed), .ref_lv(ref_lv), .pulse_pos(pos1), .pulse_neg(neg1), .period_start(stb1)
   );

   function automatic int rng_next(input int kind, input int x);
      longint p;
      int r;
      if (kind == 0) begin
         p = longint'(x) * longint'(65536 - x);
         r = int'((p * 64'd65520) >> 30);
         return (r == 0) ? 1 : r;
      end
      r = x >> 1;
      if (x % 2 == 1) r = r ^ 32'hB400;
      return r;
   endfunction

   function automatic int rn_of(input int kind, input int x);
      if (kind == 0) return x - 32768;
      return (x >= 32768) ? x - 65536 : x;
   endfunction

   function automatic int h_of(input int rn, input int c, input int s);
      int h;
      h = c + ((rn * s) >>> 15);
      if (h < 1) h = 1;
      if (h > HMAX) h = HMAX;
      return h;
   endfunction

   function automatic bit band_hit(input int rv, input int off, input int c, input int h);
      return (rv - off * E) * h > c * E;
   endfunction

   int m_cnt[2], m_half[2], m_rng[2];
   bit m_up[2];
   logic [NB-1:0] e_pos[2], e_neg[2];
   logic e_stb[2];

   always @(posedge clk or negedge rst_n) begin
      for (int i = 0; i < 2; i++) begin
         if (!rst_n) begin
            m_rng[i] = (seed == 16'd0) ? 1 : int'(seed);
            m_cnt[i] = 0; m_half[i] = 1; m_up[i] = 1'b1;
            e_pos[i] = '0; e_neg[i] = '0; e_stb[i] = 1'b0;
         end else begin
            for (int k = 0; k < NB; k++) begin
               e_pos[i][k] = band_hit(int'(ref_lv), k, m_cnt[i], m_half[i]);
               e_neg[i][k] = band_hit(int'(ref_lv), -(k + 1), m_cnt[i], m_half[i]);
            end
            e_stb[i] = (m_cnt[i] == 0);
            if (m_cnt[i] == 0) begin
               m_half[i] = h_of(rn_of(i, m_rng[i]), int'(center_half), int'(spread_half));
               m_rng[i] = rng_next(i, m_rng[i]);
               m_cnt[i] = 1; m_up[i] = 1'b1;
            end else if (m_up[i] && m_cnt[i] == m_half[i]) begin
               m_up[i] = 1'b0; m_cnt[i] = m_cnt[i] - 1;
            end else if (m_up[i]) begin
               m_cnt[i] = m_cnt[i] + 1;
            end else begin
               m_cnt[i] = m_cnt[i] - 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(stb0 == e_stb[0], "R2 R3 R4 R9 strobe logistic", stb0, e_stb[0]);
      check(pos0 == e_pos[0], "R6 pos logistic", pos0, e_pos[0]);
      check(neg0 == e_neg[0], "R7 neg logistic", neg0, e_neg[0]);
      check(stb1 == e_stb[1], "R5 R3 R9 strobe lfsr", stb1, e_stb[1]);
      check(pos1 == e_pos[1], "R6 R5 pos lfsr", pos1, e_pos[1]);
      check(neg1 == e_neg[1], "R7 R5 neg lfsr", neg1, e_neg[1]);
      check(((({1'b0, pos0, neg0[0], neg0[1], neg0[2]} + 7'd1) & {1'b0, pos0, neg0[0], neg0[1], neg0[2]}) == 0),
            "R8 thermometer", {pos0, neg0}, 0);
   endtask

   task automatic run(input int n, input bit rnd_ref);
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         compare_all();
         if (rnd_ref) ref_lv = REF_W'($signed($urandom_range(1800)) - 900);
      end
   endtask

   task automatic reset_dut(input logic [15:0] s);
      @(negedge clk);
      seed = s;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(pos0 == 0 && neg0 == 0 && stb0 == 0, "R1 reset outputs logistic", {pos0, neg0, stb0}, 0);
      check(pos1 == 0 && neg1 == 0 && stb1 == 0, "R1 reset outputs lfsr", {pos1, neg1, stb1}, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      int dir_vals[8];
      void'($urandom(32'h5EED_1234));
      dir_vals = '{0, 768, -768, 256, -256, 1023, -1024, 1};
      reset_dut(16'h1D2B);
      for (int b = 0; b < 60; b++) begin
         spread_half = 12'($urandom_range(16));
         run(100, 1'b1);
      end
      foreach (dir_vals[d]) begin
         ref_lv = REF_W'(dir_vals[d]);
         run(120, 1'b0);
      end
      center_half = 12'd3;
      spread_half = 12'd4095;
      run(9000, 1'b1);
      center_half = 12'd20;
      spread_half = 12'd12;
      reset_dut(16'h0000);
      run(2000, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule